// File: doc/BRIEF.md
# Decimating Video Capture Port

This block sits between a digital video decoder and a DMA engine. It takes 4:2:2 component samples on an 8-bit or a 16-bit bus, qualified by line-active and field-active strobes. Each of the three components (luma, blue-difference chroma, red-difference chroma) is smoothed by a short low-pass filter and thinned to half its horizontal rate. The reduced bytes are packed four to a 32-bit word and queued in a 32-word FIFO. A DMA engine watches a request line and pops words through a show-ahead read port.

A small capture state machine tracks the qualifiers. Its states are `CAP_NOFIELD` (field strobe low), `CAP_BLANK` (field active, line inactive) and `CAP_ACTIVE` (inside an active line). The transitions are:

- `CAP_NOFIELD` goes to `CAP_BLANK` or `CAP_ACTIVE` when the field strobe rises, depending on the line strobe.
- `CAP_BLANK` goes to `CAP_ACTIVE` when the line strobe rises.
- `CAP_ACTIVE` goes to `CAP_BLANK` when the line strobe falls.
- Any state returns to `CAP_NOFIELD` when the field strobe falls.

A sample taken while the machine is outside `CAP_ACTIVE` marks the start of a line. That sample resets the component phase, the filter history and the word packer.

Top module: `vcap_decim_port`

## Requirements
- R1: With `mode_wide`=0, only `vid_data[7:0]` is used. Accepted bytes from the start of a line are taken in the repeating order Cb, Y, Cr, Y, and the upper byte lane has no effect.
- R2: With `mode_wide`=1, each accepted cycle carries luma on `vid_data[7:0]` and chroma on `vid_data[15:8]`. The chroma alternates Cb, Cr, starting with Cb at the line start. Both bus modes produce the same output bytes for the same picture.
- R3: Per component, with sample index n counted from 0 at the line start, an output is produced only at odd n. Its value is (x[n-2] + 2*x[n-1] + x[n] + 2) >> 2.
- R4: Filter history is cleared at each line start, so x[-1] is taken as 0. For a flat line of value 100, the first outputs are 75.
- R5: A sample is accepted only in cycles where both `line_valid` and `field_valid` are high. Data in any other cycle produces no FIFO word and does not shift the component phase.
- R6: Output bytes are packed in production order, the first byte in bits [7:0] and the fourth in bits [31:24]. When a chroma and a luma output arise in the same cycle, the chroma byte is placed first.
- R7: An incomplete word left at the end of a line is discarded when the next line starts.
- R8: The FIFO holds 32 words in first-in first-out order. `rd_data` shows the oldest word whenever `rd_empty` is low, and `rd_en` removes it.
- R9: `dma_req` is high exactly when the FIFO holds 8 or more words.
- R10: A word produced while the FIFO holds 32 words is dropped, the stored words are unchanged, and `overflow` is set and stays set until reset.
- R11: After reset, `rd_empty`=1, `dma_req`=0 and `overflow`=0.
- R12: `rd_en` while the FIFO is empty has no effect. Later words are still read correctly from the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | Bus width select: 0 for 8-bit multiplexed, 1 for 16-bit parallel |
| vid_data | input | 16 | Video sample bus |
| line_valid | input | 1 | High during the active part of a line |
| field_valid | input | 1 | High during the active part of a field |
| rd_en | input | 1 | Pop request from the DMA side |
| rd_data | output | 32 | Oldest FIFO word (show-ahead) |
| rd_empty | output | 1 | FIFO holds no word |
| dma_req | output | 1 | FIFO holds at least the DMA threshold of words |
| overflow | output | 1 | Sticky flag for a word lost to a full FIFO |

## Verification
The hardest condition to reach from the ports is a full FIFO that still receives packed words while old contents stay intact. The stimulus holds `rd_en` low across ten 16-pixel lines, which produce 40 words against 32 slots. It then drains the FIFO, compares the survivors with the first 32 modelled words, and checks that the flag persists. Line lengths that leave a partial word are placed directly before a new line, so a stale byte would show up in the next word. Qualifier-only garbage is injected between lines to prove that the phase does not drift.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        CAP_NOFIELD = 2'd0,
        CAP_BLANK   = 2'd1,
        CAP_ACTIVE  = 2'd2
    } cap_state_t;

    localparam int NUM_CH = 3;
    localparam int CH_Y   = 0;
    localparam int CH_CB  = 1;
    localparam int CH_CR  = 2;

endpackage

// File: rtl/vcap_front.sv
module vcap_front
    import vcap_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wide,
    input  logic [2*SW-1:0] vid_data,
    input  logic            line_valid,
    input  logic            field_valid,
    output logic            y_en,
    output logic [SW-1:0]   y_smp,
    output logic            c_en,
    output logic            c_is_cr,
    output logic [SW-1:0]   c_smp,
    output logic            line_clr
);

    cap_state_t state, state_nx;
    logic [1:0] phase;
    logic [1:0] ph;
    logic       take;
    logic       start;

    assign take  = field_valid && line_valid;
    assign start = take && (state != CAP_ACTIVE);
    assign ph    = start ? 2'd0 : phase;

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_NOFIELD: begin
                if (field_valid) state_nx = line_valid ? CAP_ACTIVE : CAP_BLANK;
            end
            CAP_BLANK: begin
                if (!field_valid)    state_nx = CAP_NOFIELD;
                else if (line_valid) state_nx = CAP_ACTIVE;
            end
            CAP_ACTIVE: begin
                if (!field_valid)     state_nx = CAP_NOFIELD;
                else if (!line_valid) state_nx = CAP_BLANK;
            end
            default: state_nx = CAP_NOFIELD;
        endcase
    end

    // state register and component phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_NOFIELD;
            phase <= 2'd0;
        end else begin
            state <= state_nx;
            if (take) phase <= ph + 2'd1;
        end
    end

    // registered component decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_en     <= 1'b0;
            y_smp    <= '0;
            c_en     <= 1'b0;
            c_is_cr  <= 1'b0;
            c_smp    <= '0;
            line_clr <= 1'b0;
        end else begin
            y_en     <= 1'b0;
            c_en     <= 1'b0;
            line_clr <= start;
            if (take) begin
                if (mode_wide) begin
                    y_en    <= 1'b1;
                    y_smp   <= vid_data[SW-1:0];
                    c_en    <= 1'b1;
                    c_is_cr <= ph[0];
                    c_smp   <= vid_data[2*SW-1:SW];
                end else begin
                    unique case (ph)
                        2'd0: begin
                            c_en    <= 1'b1;
                            c_is_cr <= 1'b0;
                            c_smp   <= vid_data[SW-1:0];
                        end
                        2'd2: begin
                            c_en    <= 1'b1;
                            c_is_cr <= 1'b1;
                            c_smp   <= vid_data[SW-1:0];
                        end
                        default: begin
                            y_en  <= 1'b1;
                            y_smp <= vid_data[SW-1:0];
                        end
                    endcase
                end
            end
        end
    end

    // R1: the narrow bus never yields luma and chroma together
    assert_narrow_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (y_en && c_en) |-> $past(mode_wide));

    // R4: a line-start marker always travels with an accepted sample
    assert_clr_with_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_clr |-> (y_en || c_en));

endmodule

// File: rtl/vcap_hfilt.sv
module vcap_hfilt #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [SW-1:0] x,
    output logic          o_vld,
    output logic [SW-1:0] o_byte
);

    logic [SW-1:0] h1, h2;
    logic          odd;
    logic [SW-1:0] h1_e, h2_e;
    logic          odd_e;
    logic [SW+1:0] sum;

    always_comb begin
        h1_e  = clr ? '0 : h1;
        h2_e  = clr ? '0 : h2;
        odd_e = clr ? 1'b0 : odd;
        sum   = {2'b00, h2_e} + {1'b0, h1_e, 1'b0} + {2'b00, x} + (SW+2)'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1     <= '0;
            h2     <= '0;
            odd    <= 1'b0;
            o_vld  <= 1'b0;
            o_byte <= '0;
        end else begin
            o_vld <= 1'b0;
            if (en) begin
                h2  <= h1_e;
                h1  <= x;
                odd <= ~odd_e;
                if (odd_e) begin
                    o_vld  <= 1'b1;
                    o_byte <= SW'(sum >> 2);
                end
            end else if (clr) begin
                h1  <= '0;
                h2  <= '0;
                odd <= 1'b0;
            end
        end
    end

    // R3: decimation by two never emits on two consecutive cycles
    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |=> !o_vld);

endmodule

// File: rtl/vcap_pack.sv
module vcap_pack #(
    parameter int SW    = 8,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                a_vld,
    input  logic [SW-1:0]       a_byte,
    input  logic                b_vld,
    input  logic [SW-1:0]       b_byte,
    output logic                wr_en,
    output logic [LANES*SW-1:0] wr_word
);

    localparam int FW = $clog2(LANES);
    localparam logic [FW-1:0] LAST = FW'(LANES - 1);

    logic [SW-1:0]       slot   [LANES];
    logic [SW-1:0]       slot_n [LANES];
    logic [FW-1:0]       fill, fill_nx;
    logic                done_nx;
    logic [LANES*SW-1:0] word_nx;
    logic                in_v [2];
    logic [SW-1:0]       in_b [2];

    always_comb begin
        in_v[0] = a_vld;
        in_b[0] = a_byte;
        in_v[1] = b_vld;
        in_b[1] = b_byte;
        for (int i = 0; i < LANES; i++) slot_n[i] = slot[i];
        fill_nx = clr ? '0 : fill;
        done_nx = 1'b0;
        word_nx = '0;
        for (int k = 0; k < 2; k++) begin
            if (in_v[k]) begin
                slot_n[fill_nx] = in_b[k];
                if (fill_nx == LAST) begin
                    done_nx = 1'b1;
                    for (int j = 0; j < LANES; j++) word_nx[j*SW +: SW] = slot_n[j];
                    fill_nx = '0;
                end else begin
                    fill_nx = fill_nx + FW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) slot[i] <= '0;
            fill    <= '0;
            wr_en   <= 1'b0;
            wr_word <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) slot[i] <= slot_n[i];
            fill  <= fill_nx;
            wr_en <= done_nx;
            if (done_nx) wr_word <= word_nx;
        end
    end

    // R6: at most two bytes per cycle, so words are never written back to back
    assert_word_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/vcap_fifo.sv
module vcap_fifo #(
    parameter int WW     = 32,
    parameter int DEPTH  = 32,
    parameter int THRESH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_word,
    input  logic          rd_en,
    output logic [WW-1:0] rd_data,
    output logic          rd_empty,
    output logic          dma_req,
    output logic          overflow
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   DEPTH_L  = (AW+1)'(DEPTH);
    localparam logic [AW:0]   THRESH_L = (AW+1)'(THRESH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, push, pop;

    assign full     = (count == DEPTH_L);
    assign rd_empty = (count == '0);
    assign push     = wr_en && !full;
    assign pop      = rd_en && !rd_empty;
    assign rd_data  = mem[rd_ptr];
    assign dma_req  = (count >= THRESH_L);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
            unique case ({push, pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    // R8: fill level never exceeds the storage
    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_L);

    // R9: reaching the threshold raises the request on the next cycle
    assert_dma_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == THRESH_L - (AW+1)'(1)) |=> dma_req);

    // R10: the overflow flag is sticky
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10: a write into a full FIFO moves no write pointer
    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_ptr));

    // R12: a read request on an empty FIFO leaves the read pointer alone
    assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_empty) |=> $stable(rd_ptr));

endmodule

// File: rtl/vcap_decim_port.sv
module vcap_decim_port
    import vcap_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int WORD_LANES = 4,
    parameter int FIFO_DEPTH = 32,
    parameter int DMA_THRESH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_wide,
    input  logic [2*SAMPLE_W-1:0]        vid_data,
    input  logic                         line_valid,
    input  logic                         field_valid,
    input  logic                         rd_en,
    output logic [WORD_LANES*SAMPLE_W-1:0] rd_data,
    output logic                         rd_empty,
    output logic                         dma_req,
    output logic                         overflow
);

    localparam int WW = WORD_LANES * SAMPLE_W;

    logic                y_en, c_en, c_is_cr, line_clr;
    logic [SAMPLE_W-1:0] y_smp, c_smp;
    logic                clr_q;

    logic                ch_en   [NUM_CH];
    logic [SAMPLE_W-1:0] ch_x    [NUM_CH];
    logic                ch_vld  [NUM_CH];
    logic [SAMPLE_W-1:0] ch_byte [NUM_CH];

    logic                chroma_vld;
    logic [SAMPLE_W-1:0] chroma_byte;
    logic                pk_wr;
    logic [WW-1:0]       pk_word;

    vcap_front #(.SW(SAMPLE_W)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wide   (mode_wide),
        .vid_data    (vid_data),
        .line_valid  (line_valid),
        .field_valid (field_valid),
        .y_en        (y_en),
        .y_smp       (y_smp),
        .c_en        (c_en),
        .c_is_cr     (c_is_cr),
        .c_smp       (c_smp),
        .line_clr    (line_clr)
    );

    always_comb begin
        ch_en[CH_Y]  = y_en;
        ch_x[CH_Y]   = y_smp;
        ch_en[CH_CB] = c_en && !c_is_cr;
        ch_x[CH_CB]  = c_smp;
        ch_en[CH_CR] = c_en && c_is_cr;
        ch_x[CH_CR]  = c_smp;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        vcap_hfilt #(.SW(SAMPLE_W)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (line_clr),
            .en     (ch_en[g]),
            .x      (ch_x[g]),
            .o_vld  (ch_vld[g]),
            .o_byte (ch_byte[g])
        );
    end

    // packer clear follows the filter stage by one register
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= line_clr;
    end

    assign chroma_vld  = ch_vld[CH_CB] || ch_vld[CH_CR];
    assign chroma_byte = ch_vld[CH_CR] ? ch_byte[CH_CR] : ch_byte[CH_CB];

    vcap_pack #(.SW(SAMPLE_W), .LANES(WORD_LANES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_q),
        .a_vld   (chroma_vld),
        .a_byte  (chroma_byte),
        .b_vld   (ch_vld[CH_Y]),
        .b_byte  (ch_byte[CH_Y]),
        .wr_en   (pk_wr),
        .wr_word (pk_word)
    );

    vcap_fifo #(.WW(WW), .DEPTH(FIFO_DEPTH), .THRESH(DMA_THRESH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pk_wr),
        .wr_word  (pk_word),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty),
        .dma_req  (dma_req),
        .overflow (overflow)
    );

    // R2: the two chroma filters never produce in the same cycle
    assert_chroma_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_vld[CH_CB] && ch_vld[CH_CR]));

endmodule

// File: tb/test_vcap_decim_port.sv
module test_vcap_decim_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b0;
    logic [15:0] vid_data = '0;
    logic        line_valid = 1'b0;
    logic        field_valid = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_empty, dma_req, overflow;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int ys [0:63];
    int cbs[0:31];
    int crs[0:31];
    logic [31:0] exp_q[$];
    logic [7:0]  bts[0:127];

    always #2 clk = ~clk;

    vcap_decim_port i_vcap_decim_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wide   (mode_wide),
        .vid_data    (vid_data),
        .line_valid  (line_valid),
        .field_valid (field_valid),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_empty    (rd_empty),
        .dma_req     (dma_req),
        .overflow    (overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    function automatic int filt(input int a, input int b, input int c);
        return (a + 2*b + c + 2) >> 2;
    endfunction

    // expected bytes in production order, packed LSB first, partial word dropped
    function automatic void model_line(input int npix);
        int nb = 0;
        for (int k = 0; k < npix/2; k++) begin
            if (k % 2 == 1) bts[nb++] = 8'(filt(k >= 2 ? cbs[k-2] : 0, cbs[k-1], cbs[k]));
            if (k % 2 == 1) bts[nb++] = 8'(filt(k >= 2 ? crs[k-2] : 0, crs[k-1], crs[k]));
            bts[nb++] = 8'(filt(2*k >= 1 ? ys[2*k-1] : 0, ys[2*k], ys[2*k+1]));
            if (k % 2 == 1) begin
                // restore order: Cb at pair start, Y(2k) produces nothing, Cr, then Y(2k+1)
                logic [7:0] cbv, crv, yv;
                cbv = bts[nb-3]; crv = bts[nb-2]; yv = bts[nb-1];
                bts[nb-3] = cbv; bts[nb-2] = crv; bts[nb-1] = yv;
            end
        end
        for (int w = 0; w < nb/4; w++) begin
            if (exp_q.size() < 32)
                exp_q.push_back({bts[4*w+3], bts[4*w+2], bts[4*w+1], bts[4*w]});
        end
    endfunction

    task automatic fill_pix(input int npix, input bit rnd, input int val);
        for (int i = 0; i < npix; i++) ys[i] = rnd ? int'($urandom_range(255)) : val;
        for (int i = 0; i < npix/2; i++) begin
            cbs[i] = rnd ? int'($urandom_range(255)) : val;
            crs[i] = rnd ? int'($urandom_range(255)) : val;
        end
    endtask

    task automatic send_line(input bit wide, input int npix);
        model_line(npix);
        mode_wide  = wide;
        line_valid = 1'b1;
        if (wide) begin
            for (int j = 0; j < npix; j++) begin
                vid_data = {8'((j % 2 == 0) ? cbs[j/2] : crs[j/2]), 8'(ys[j])};
                @(negedge clk);
            end
        end else begin
            for (int k = 0; k < npix/2; k++) begin
                vid_data = {8'($urandom), 8'(cbs[k])};   @(negedge clk);
                vid_data = {8'($urandom), 8'(ys[2*k])};  @(negedge clk);
                vid_data = {8'($urandom), 8'(crs[k])};   @(negedge clk);
                vid_data = {8'($urandom), 8'(ys[2*k+1])}; @(negedge clk);
            end
        end
        line_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            vid_data = 16'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic drain(input string req);
        repeat (10) @(negedge clk);
        while (exp_q.size() > 0) begin
            chk(!rd_empty, "R8 empty while data expected", {31'd0, rd_empty}, 32'd0);
            chk(rd_data == exp_q[0], req, rd_data, exp_q[0]);
            void'(exp_q.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            chk(dma_req == (exp_q.size() >= 8), "R9 dma_req level", {31'd0, dma_req},
                {31'd0, exp_q.size() >= 8});
        end
        chk(rd_empty == 1'b1, "R8 empty after drain", {31'd0, rd_empty}, 32'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // R11: reset state
        chk(rd_empty == 1'b1, "R11 rd_empty", {31'd0, rd_empty}, 32'd1);
        chk(dma_req == 1'b0, "R11 dma_req", {31'd0, dma_req}, 32'd0);
        chk(overflow == 1'b0, "R11 overflow", {31'd0, overflow}, 32'd0);

        // R12: read requests on an empty FIFO
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk(rd_empty == 1'b1, "R12 empty after empty read", {31'd0, rd_empty}, 32'd1);
        field_valid = 1'b1;
        @(negedge clk);

        // R4 / R1: flat 8-bit line, first word 75,75,75,100
        fill_pix(8, 1'b0, 100);
        send_line(1'b0, 8);
        repeat (6) @(negedge clk);
        chk(rd_data == 32'h644B4B4B, "R4 first word after cleared history", rd_data, 32'h644B4B4B);
        drain("R12 R1 narrow flat line");

        // R2: same picture on the wide bus gives the same words
        send_line(1'b1, 8);
        repeat (6) @(negedge clk);
        chk(rd_data == 32'h644B4B4B, "R2 wide bus first word", rd_data, 32'h644B4B4B);
        drain("R2 wide flat line");

        // R5: garbage outside active line/field
        line_valid = 1'b1; field_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin vid_data = 16'($urandom); @(negedge clk); end
        line_valid = 1'b0; field_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin vid_data = 16'($urandom); @(negedge clk); end
        repeat (8) @(negedge clk);
        chk(rd_empty == 1'b1, "R5 no word from unqualified data", {31'd0, rd_empty}, 32'd1);
        fill_pix(16, 1'b1, 0);
        send_line(1'b0, 16);
        drain("R5 phase intact after unqualified data");

        // R7: short line leaves a partial word, next line must start clean
        fill_pix(6, 1'b1, 0);
        send_line(1'b1, 6);
        fill_pix(8, 1'b1, 0);
        send_line(1'b0, 8);
        drain("R7 partial word discarded");
        fill_pix(10, 1'b1, 0);
        send_line(1'b0, 10);
        fill_pix(12, 1'b1, 0);
        send_line(1'b1, 12);
        drain("R7 partial word discarded across modes");

        // R3 / R6: random lines in both modes
        for (int n = 0; n < 12; n++) begin
            int np;
            bit wd;
            np = 4 + 2 * int'($urandom_range(14));
            wd = 1'($urandom_range(1));
            fill_pix(np, 1'b1, 0);
            send_line(wd, np);
            drain("R3 R6 random line data");
        end

        // R9: threshold crossing without draining
        fill_pix(16, 1'b1, 0);
        send_line(1'b1, 16);
        repeat (8) @(negedge clk);
        chk(dma_req == 1'b0, "R9 below threshold", {31'd0, dma_req}, 32'd0);
        fill_pix(16, 1'b1, 0);
        send_line(1'b0, 16);
        repeat (8) @(negedge clk);
        chk(dma_req == 1'b1, "R9 at threshold", {31'd0, dma_req}, 32'd1);

        // R10: overfill to 40 words
        for (int n = 0; n < 8; n++) begin
            fill_pix(16, 1'b1, 0);
            send_line(n % 2 == 0, 16);
        end
        repeat (8) @(negedge clk);
        chk(overflow == 1'b1, "R10 overflow set", {31'd0, overflow}, 32'd1);
        drain("R10 stored words survive overflow");
        fill_pix(8, 1'b1, 0);
        send_line(1'b0, 8);
        drain("R10 capture resumes after overflow");
        chk(overflow == 1'b1, "R10 overflow sticky", {31'd0, overflow}, 32'd1);

        // R11: reset clears the flag
        field_valid = 1'b0;
        do_reset();
        chk(overflow == 1'b0, "R11 overflow after reset", {31'd0, overflow}, 32'd0);
        chk(rd_empty == 1'b1, "R11 empty after reset", {31'd0, rd_empty}, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule